// File: doc/BRIEF.md
# Debug Show Cycle Controller

The block sits between the processor's internal bus and the external bus pins. It decides which external signals are driven when a transfer is made. When a transfer targets an on-chip module, the external address, function code, size and read/write outputs still follow the internal bus. The external strobes and the data bus are normally kept quiet. For debugging, a 2-bit show-cycle enable field can be set in a configuration register. While it is set, internal transfers become visible on the external bus: the data strobe marks the address-strobe timing, the address strobe stays negated, and the internal data is driven out.

Transfers that go to the external bus pass their strobes, data and data output enable through unchanged, whatever the enable field holds. All outputs are registered and appear one clock after the inputs that cause them. A write to the enable field applies to transfers presented from the cycle after the write edge.

Top module: `show_cycle_ctrl`

## Requirements
- R1: While rst_ni is low and after reset, cfg_rdata_o is 2'b00 (show cycles disabled). ext_as_o, ext_ds_o and ext_data_oe_o are 0, and ext_data_o is all zeros.
- R2: A cycle with cfg_we_i high stores cfg_wdata_i. cfg_rdata_o returns the stored value from the next clock edge on.
- R3: Every nonzero enable value (2'b01, 2'b10, 2'b11) enables show cycles. 2'b00 disables them.
- R4: ext_addr_o, ext_fc_o, ext_size_o and ext_rw_o equal the values of bus_addr_i, bus_fc_i, bus_size_i and bus_rw_i one cycle earlier. This holds for every transfer type and enable setting.
- R5: When int_sel_i is 1 and show cycles are disabled, the next cycle has ext_as_o=0, ext_ds_o=0, ext_data_oe_o=0 and ext_data_o all zeros.
- R6: When int_sel_i is 1 and show cycles are enabled, the next cycle has ext_as_o=0 and ext_ds_o equal to the earlier bus_as_i. ext_data_o carries the earlier bus_data_i while the data output enable is high, and is zero otherwise.
- R7: On a show cycle, ext_data_oe_o is high in each cycle that follows a cycle with bus_as_i high. It drops in the cycle after bus_as_i negates.
- R8: When int_sel_i is 0, the next cycle has ext_as_o, ext_ds_o and ext_data_oe_o equal to the earlier bus_as_i, bus_ds_i and bus_doe_i. ext_data_o equals bus_data_i when bus_doe_i was 1, and zero otherwise. This does not depend on the enable field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Enable-field write strobe |
| cfg_wdata_i | input | 2 | Enable-field write value |
| cfg_rdata_o | output | 2 | Enable-field readback |
| int_sel_i | input | 1 | 1 = transfer targets an on-chip module |
| bus_addr_i | input | AW | Bus cycle address |
| bus_fc_i | input | 3 | Bus cycle function code |
| bus_size_i | input | 2 | Bus cycle size |
| bus_rw_i | input | 1 | Bus cycle read/write |
| bus_as_i | input | 1 | Cycle address strobe (internal strobe for on-chip transfers) |
| bus_ds_i | input | 1 | Cycle data strobe |
| bus_data_i | input | DW | Cycle data |
| bus_doe_i | input | 1 | Data output enable requested by an external transfer |
| ext_addr_o | output | AW | External address |
| ext_fc_o | output | 3 | External function code |
| ext_size_o | output | 2 | External size |
| ext_rw_o | output | 1 | External read/write |
| ext_as_o | output | 1 | External address strobe |
| ext_ds_o | output | 1 | External data strobe |
| ext_data_o | output | DW | External data bus value |
| ext_data_oe_o | output | 1 | External data bus output enable (0 = high impedance) |

## Verification
Every bus output is due exactly one clock after the negedge at which the driver presents a transfer. Enable-field readback is due after the clock edge that follows the write. The driver applies a transfer on a falling edge and pushes the expected output set, computed from its own copy of the enable field, into a queue. The monitor pops one item 2 ns after each rising edge, so every comparison lands in the single cycle where that transfer's result is held. Enable writes are completed one cycle before the next transfer is presented, so that the driver's copy of the field and the register agree.

// File: rtl/show_cycle_pkg.sv
package show_cycle_pkg;
  localparam int unsigned EN_W   = 2;
  localparam int unsigned FC_W   = 3;
  localparam int unsigned SIZE_W = 2;

  typedef enum logic [1:0] {
    PATH_EXT  = 2'd0,  // external transfer, pass-through
    PATH_HIDE = 2'd1,  // internal, show disabled
    PATH_SHOW = 2'd2   // internal, show enabled
  } path_mode_e;
endpackage

// File: rtl/show_cfg_reg.sv
module show_cfg_reg
  import show_cycle_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [EN_W-1:0] wdata_i,
  output logic [EN_W-1:0] rdata_o,
  output logic            show_en_o
);
  logic [EN_W-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   en_q <= '0;
    else if (we_i) en_q <= wdata_i;
  end

  assign rdata_o   = en_q;
  assign show_en_o = |en_q;
endmodule

// File: rtl/show_path_dec.sv
module show_path_dec
  import show_cycle_pkg::*;
(
  input  logic       int_sel_i,
  input  logic       show_en_i,
  output path_mode_e mode_o
);
  always_comb begin
    if (!int_sel_i)     mode_o = PATH_EXT;
    else if (show_en_i) mode_o = PATH_SHOW;
    else                mode_o = PATH_HIDE;
  end
endmodule

// File: rtl/show_attr_stage.sv
module show_attr_stage
  import show_cycle_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic [FC_W-1:0]   fc_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              rw_i,
  output logic [AW-1:0]     addr_o,
  output logic [FC_W-1:0]   fc_o,
  output logic [SIZE_W-1:0] size_o,
  output logic              rw_o
);
  // attributes follow the internal bus for every transfer type
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      fc_o   <= '0;
      size_o <= '0;
      rw_o   <= 1'b1;
    end else begin
      addr_o <= addr_i;
      fc_o   <= fc_i;
      size_o <= size_i;
      rw_o   <= rw_i;
    end
  end
endmodule

// File: rtl/show_strobe_data.sv
module show_strobe_data
  import show_cycle_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  path_mode_e    mode_i,
  input  logic          as_i,
  input  logic          ds_i,
  input  logic          doe_i,
  input  logic [DW-1:0] data_i,
  output logic          as_o,
  output logic          ds_o,
  output logic          oe_o,
  output logic [DW-1:0] data_o
);
  logic          as_d, ds_d, oe_d;
  logic [DW-1:0] data_d;

  always_comb begin
    as_d = 1'b0;
    ds_d = 1'b0;
    oe_d = 1'b0;
    unique case (mode_i)
      PATH_EXT: begin
        as_d = as_i;
        ds_d = ds_i;
        oe_d = doe_i;
      end
      PATH_SHOW: begin
        // data strobe carries address-strobe timing; AS stays quiet
        ds_d = as_i;
        oe_d = as_i;
      end
      default: ;
    endcase
    data_d = oe_d ? data_i : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      as_o   <= 1'b0;
      ds_o   <= 1'b0;
      oe_o   <= 1'b0;
      data_o <= '0;
    end else begin
      as_o   <= as_d;
      ds_o   <= ds_d;
      oe_o   <= oe_d;
      data_o <= data_d;
    end
  end
endmodule

// File: rtl/show_cycle_ctrl.sv
module show_cycle_ctrl
  import show_cycle_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [EN_W-1:0]   cfg_wdata_i,
  output logic [EN_W-1:0]   cfg_rdata_o,
  input  logic              int_sel_i,
  input  logic [AW-1:0]     bus_addr_i,
  input  logic [FC_W-1:0]   bus_fc_i,
  input  logic [SIZE_W-1:0] bus_size_i,
  input  logic              bus_rw_i,
  input  logic              bus_as_i,
  input  logic              bus_ds_i,
  input  logic [DW-1:0]     bus_data_i,
  input  logic              bus_doe_i,
  output logic [AW-1:0]     ext_addr_o,
  output logic [FC_W-1:0]   ext_fc_o,
  output logic [SIZE_W-1:0] ext_size_o,
  output logic              ext_rw_o,
  output logic              ext_as_o,
  output logic              ext_ds_o,
  output logic [DW-1:0]     ext_data_o,
  output logic              ext_data_oe_o
);
  logic       show_en;
  path_mode_e mode;

  show_cfg_reg u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i),
    .wdata_i   (cfg_wdata_i),
    .rdata_o   (cfg_rdata_o),
    .show_en_o (show_en)
  );

  show_path_dec u_dec (
    .int_sel_i (int_sel_i),
    .show_en_i (show_en),
    .mode_o    (mode)
  );

  show_attr_stage #(.AW(AW)) u_attr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (bus_addr_i),
    .fc_i   (bus_fc_i),
    .size_i (bus_size_i),
    .rw_i   (bus_rw_i),
    .addr_o (ext_addr_o),
    .fc_o   (ext_fc_o),
    .size_o (ext_size_o),
    .rw_o   (ext_rw_o)
  );

  show_strobe_data #(.DW(DW)) u_strb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode),
    .as_i   (bus_as_i),
    .ds_i   (bus_ds_i),
    .doe_i  (bus_doe_i),
    .data_i (bus_data_i),
    .as_o   (ext_as_o),
    .ds_o   (ext_ds_o),
    .oe_o   (ext_data_oe_o),
    .data_o (ext_data_o)
  );
endmodule

// File: rtl/show_cycle_ctrl_chk.sv
module show_cycle_ctrl_chk #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cfg_we_i,
  input logic [1:0]    cfg_wdata_i,
  input logic [1:0]    cfg_rdata_o,
  input logic          int_sel_i,
  input logic [AW-1:0] bus_addr_i,
  input logic          bus_as_i,
  input logic          bus_ds_i,
  input logic          bus_doe_i,
  input logic [DW-1:0] bus_data_i,
  input logic [AW-1:0] ext_addr_o,
  input logic          ext_as_o,
  input logic          ext_ds_o,
  input logic [DW-1:0] ext_data_o,
  input logic          ext_data_oe_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_quiet_chk: assert (cfg_rdata_o == 2'b00 && !ext_as_o && !ext_ds_o && !ext_data_oe_o);
    end
  end

  // R2
  cfg_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(cfg_we_i) |-> cfg_rdata_o == $past(cfg_wdata_i));

  // R4
  addr_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> ext_addr_o == $past(bus_addr_i));

  // R5
  hidden_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(int_sel_i && cfg_rdata_o == 2'b00) |-> !ext_as_o && !ext_ds_o && !ext_data_oe_o);

  // R6
  show_ds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(int_sel_i && cfg_rdata_o != 2'b00) |-> !ext_as_o && ext_ds_o == $past(bus_as_i));

  // R7
  show_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(int_sel_i && cfg_rdata_o != 2'b00) |->
      ext_data_oe_o == $past(bus_as_i) && (!ext_data_oe_o || ext_data_o == $past(bus_data_i)));

  // R8
  ext_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(!int_sel_i) |->
      ext_as_o == $past(bus_as_i) && ext_ds_o == $past(bus_ds_i) && ext_data_oe_o == $past(bus_doe_i));
endmodule

bind show_cycle_ctrl show_cycle_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cfg_we_i      (cfg_we_i),
  .cfg_wdata_i   (cfg_wdata_i),
  .cfg_rdata_o   (cfg_rdata_o),
  .int_sel_i     (int_sel_i),
  .bus_addr_i    (bus_addr_i),
  .bus_as_i      (bus_as_i),
  .bus_ds_i      (bus_ds_i),
  .bus_doe_i     (bus_doe_i),
  .bus_data_i    (bus_data_i),
  .ext_addr_o    (ext_addr_o),
  .ext_as_o      (ext_as_o),
  .ext_ds_o      (ext_ds_o),
  .ext_data_o    (ext_data_o),
  .ext_data_oe_o (ext_data_oe_o)
);

// File: tb/show_cycle_ctrl_bench.sv
module show_cycle_ctrl_bench;
  localparam int AW = 32;
  localparam int DW = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cfg_we_i = 1'b0;
  logic [1:0]    cfg_wdata_i = '0;
  logic [1:0]    cfg_rdata_o;
  logic          int_sel_i = 1'b0;
  logic [AW-1:0] bus_addr_i = '0;
  logic [2:0]    bus_fc_i = '0;
  logic [1:0]    bus_size_i = '0;
  logic          bus_rw_i = 1'b1;
  logic          bus_as_i = 1'b0;
  logic          bus_ds_i = 1'b0;
  logic [DW-1:0] bus_data_i = '0;
  logic          bus_doe_i = 1'b0;
  logic [AW-1:0] ext_addr_o;
  logic [2:0]    ext_fc_o;
  logic [1:0]    ext_size_o;
  logic          ext_rw_o;
  logic          ext_as_o;
  logic          ext_ds_o;
  logic [DW-1:0] ext_data_o;
  logic          ext_data_oe_o;

  always #5 clk_i = ~clk_i;

  show_cycle_ctrl #(.AW(AW), .DW(DW)) u_show_cycle_ctrl (.*);

  typedef struct {
    logic [AW-1:0] addr;
    logic [2:0]    fc;
    logic [1:0]    size;
    logic          rw;
    logic          as_b;
    logic          ds_b;
    logic [DW-1:0] data;
    logic          oe;
    string         tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_run = 0;
  int   n_fail = 0;
  logic [1:0] tb_cfg = 2'b00;
  bit   done = 1'b0;

  task automatic check(input bit ok, input string tag, input string act, input string exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%s expected=%s", tag, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [1:0] v);
    @(negedge clk_i);
    cfg_we_i    = 1'b1;
    cfg_wdata_i = v;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    tb_cfg   = v;
    check(cfg_rdata_o == v, "R2", $sformatf("%b", cfg_rdata_o), $sformatf("%b", v));
  endtask

  task automatic xfer(input logic isel, input logic as_v, input logic ds_v, input logic doe_v,
                      input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
    exp_t e;
    @(negedge clk_i);
    int_sel_i  = isel;
    bus_as_i   = as_v;
    bus_ds_i   = ds_v;
    bus_doe_i  = doe_v;
    bus_addr_i = a;
    bus_data_i = d;
    bus_fc_i   = a[2:0];
    bus_size_i = a[4:3];
    bus_rw_i   = a[5];
    e.addr = a; e.fc = a[2:0]; e.size = a[4:3]; e.rw = a[5]; e.tag = tag;
    if (!isel) begin
      e.as_b = as_v; e.ds_b = ds_v; e.oe = doe_v;
    end else if (tb_cfg != 2'b00) begin
      e.as_b = 1'b0; e.ds_b = as_v; e.oe = as_v;
    end else begin
      e.as_b = 1'b0; e.ds_b = 1'b0; e.oe = 1'b0;
    end
    e.data = e.oe ? d : '0;
    exp_q.push_back(e);
  endtask

  // monitor
  always @(posedge clk_i) begin
    #2;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check({ext_addr_o, ext_fc_o, ext_size_o, ext_rw_o} == {e.addr, e.fc, e.size, e.rw},
            {e.tag, "/R4"}, $sformatf("%h", ext_addr_o), $sformatf("%h", e.addr));
      check({ext_as_o, ext_ds_o, ext_data_oe_o, ext_data_o} == {e.as_b, e.ds_b, e.oe, e.data}, e.tag,
            $sformatf("as=%b ds=%b oe=%b d=%h", ext_as_o, ext_ds_o, ext_data_oe_o, ext_data_o),
            $sformatf("as=%b ds=%b oe=%b d=%h", e.as_b, e.ds_b, e.oe, e.data));
    end
  end

  initial begin
    #20000;
    check(1'b0, "watchdog", "timeout", "done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #12;
    // R1 reset state
    check(cfg_rdata_o == 2'b00 && !ext_as_o && !ext_ds_o && !ext_data_oe_o && ext_data_o == '0,
          "R1", $sformatf("cfg=%b as=%b ds=%b oe=%b", cfg_rdata_o, ext_as_o, ext_ds_o, ext_data_oe_o), "all 0");
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(cfg_rdata_o == 2'b00, "R1", $sformatf("%b", cfg_rdata_o), "00");

    // R5 hidden internal transfers
    xfer(1'b1, 1'b1, 1'b1, 1'b1, 32'h0000_1234, 16'hBEEF, "R5");
    xfer(1'b1, 1'b1, 1'b0, 1'b0, 32'h0000_1238, 16'hCAFE, "R5");
    xfer(1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 16'h0000, "R5");
    // R8 external with show disabled
    xfer(1'b0, 1'b1, 1'b1, 1'b1, 32'hFFFF_0021, 16'h5A5A, "R8");
    xfer(1'b0, 1'b1, 1'b0, 1'b0, 32'hFFFF_0022, 16'h1111, "R8");

    // R3/R6/R7 show enable with value 01
    write_cfg(2'b01);
    xfer(1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_2000, 16'h0001, "R6");
    xfer(1'b1, 1'b1, 1'b0, 1'b0, 32'h0000_2004, 16'hA1A1, "R7");
    xfer(1'b1, 1'b1, 1'b1, 1'b0, 32'h0000_2004, 16'hA2A2, "R7");
    xfer(1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_2008, 16'hA3A3, "R7");
    // R8 external unaffected by show enable
    xfer(1'b0, 1'b0, 1'b1, 1'b1, 32'h8000_003F, 16'h7777, "R8");
    xfer(1'b0, 1'b1, 1'b1, 1'b0, 32'h8000_0010, 16'h8888, "R8");

    // R3 other nonzero values
    write_cfg(2'b10);
    xfer(1'b1, 1'b1, 1'b0, 1'b0, 32'h0000_3000, 16'h3C3C, "R3");
    write_cfg(2'b11);
    xfer(1'b1, 1'b1, 1'b0, 1'b0, 32'h0000_3010, 16'h4D4D, "R3");
    xfer(1'b1, 1'b0, 1'b1, 1'b1, 32'h0000_3014, 16'h4E4E, "R6");

    // back to disabled
    write_cfg(2'b00);
    xfer(1'b1, 1'b1, 1'b1, 1'b1, 32'h0000_4000, 16'hDEAD, "R3");
    xfer(1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 16'h0000, "R8");

    @(negedge clk_i);
    @(negedge clk_i);
    check(exp_q.size() == 0, "queue", $sformatf("%0d", exp_q.size()), "0");
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule